// File: doc/BRIEF.md
# Frame-Synchronized Serial Word Receiver

This block is the receive half of a slave-mode serial port. A remote master drives a bit clock, a serial data line and a frame-sync line; the block looks at all three only on the chosen edge of that external clock. The block runs on a local system clock. The three serial lines pass through a shared synchronizer, and an edge detector produces one sampling strobe for each selected edge of the bit clock. Frame sync is read with a selectable polarity.

A word begins on a sampling edge that sees frame sync active when the edge before it saw frame sync inactive. The first data bit is taken on that same edge, most significant bit first. Once a word has begun, frame-sync activity is ignored until all bits have arrived. The finished word is then copied into a holding register and a ready flag is set. Before any frame can begin, the receiver must see two sampling edges after reset. Until then frame sync has no effect. This means that a master which gates its clock off between frames, and which only starts the clock while frame sync is already active, never produces a frame.

Top module: `fsrx_top`

## Requirements
- R1: After reset, rx_ready, rx_overrun and rx_synced are 0 and rx_word is all zeros.
- R2: Frame sync and data are read only on the selected edge of rx_clk: cfg_edge=1 selects the rising edge and cfg_edge=0 selects the falling edge. Changes of rx_fs while rx_clk does not move have no effect.
- R3: cfg_fs_active_low=1 makes a low rx_fs the active level. cfg_fs_active_low=0 makes a high rx_fs the active level.
- R4: rx_synced rises after the second sampling edge following reset and then stays high. Frame sync seen on the first two sampling edges cannot start a frame.
- R5: A frame starts only on a sampling edge with frame sync active when the previous sampling edge had frame sync inactive. If frame sync is active on every sampling edge, no word is ever received.
- R6: The data bit taken on the frame-start edge becomes the most significant bit of rx_word. The following WORD_BITS-1 sampling edges supply the remaining bits in order down to bit 0.
- R7: Frame-sync activity while a word is in progress, including a new inactive-to-active transition, neither restarts nor alters that word.
- R8: When the last bit of a word is taken while rx_ready is 0, rx_word takes the new word and rx_ready goes to 1.
- R9: A one-cycle pulse on rd_strobe clears rx_ready and rx_overrun, and rx_word keeps its value.
- R10: When a word completes while rx_ready is 1, rx_word keeps the older word and rx_overrun goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_clk | input | 1 | Bit clock from the remote master |
| rx_fs | input | 1 | Frame sync from the remote master |
| rx_data | input | 1 | Serial data from the remote master |
| cfg_edge | input | 1 | 1: sample on rising rx_clk edge, 0: falling |
| cfg_fs_active_low | input | 1 | 1: frame sync active low, 0: active high |
| rd_strobe | input | 1 | Read of the holding register; clears the flags |
| rx_word | output | WORD_BITS | Holding register with the last accepted word |
| rx_ready | output | 1 | A word is waiting to be read |
| rx_overrun | output | 1 | A word was lost because the holding register was full |
| rx_synced | output | 1 | The two post-reset clock edges have been seen |

## Verification
The hardest case to produce is the one where the clock is gated. Frame sync has to change while rx_clk is parked, and the clock then resumes with frame sync already active, so the receiver never samples an inactive level. The bench reaches this case by moving rx_fs between sampling edges without moving rx_clk, and then supplying edges with frame sync held active. In a related case, frame sync goes inactive and then active during the two synchronization edges, so a detector that does not wait for synchronization would start a word too early. The bench then mixes random words, random pulse widths, mid-word frame-sync glitches, reads that are skipped (which produce overruns), and both edge and polarity settings.

// File: rtl/fsrx_pkg.sv
package fsrx_pkg;
  // Values of the sampling-edge select input
  localparam logic EDGE_FALL = 1'b0;
  localparam logic EDGE_RISE = 1'b1;

  // Sampling edges required after reset before frames are accepted
  localparam int unsigned SYNC_EDGES_DEF = 2;
endpackage

// File: rtl/fsrx_in_sync.sv
module fsrx_in_sync #(
  parameter int unsigned LINES  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);
  logic [LINES-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/fsrx_frame_ctrl.sv
module fsrx_frame_ctrl
  import fsrx_pkg::*;
#(
  parameter int unsigned WORD_BITS  = 8,
  parameter int unsigned SYNC_EDGES = SYNC_EDGES_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_lvl,
  input  logic                 fs_lvl,
  input  logic                 data_lvl,
  input  logic                 cfg_edge,
  input  logic                 cfg_fs_active_low,
  output logic                 synced,
  output logic                 word_done,
  output logic [WORD_BITS-1:0] word_val
);
  localparam int unsigned BCW = $clog2(WORD_BITS + 1);
  localparam int unsigned SCW = $clog2(SYNC_EDGES + 1);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(WORD_BITS - 1);
  localparam logic [SCW-1:0] SYNC_DONE = SCW'(SYNC_EDGES);

  logic                 primed_q;
  logic                 clk_prev_q;
  logic [SCW-1:0]       sync_cnt_q, sync_cnt_d;
  logic                 fs_idle_q, fs_idle_d;
  logic                 busy_q, busy_d;
  logic [BCW-1:0]       bit_cnt_q, bit_cnt_d;
  logic [WORD_BITS-1:0] shift_q, shift_d;
  logic                 sample_en;
  logic                 fs_act;

  // Sampling strobe on the selected edge of the synchronized bit clock
  always_comb begin
    if (cfg_edge == EDGE_RISE) sample_en = primed_q &  clk_lvl & ~clk_prev_q;
    else                       sample_en = primed_q & ~clk_lvl &  clk_prev_q;
  end

  assign fs_act = fs_lvl ^ cfg_fs_active_low;
  assign synced = (sync_cnt_q == SYNC_DONE);

  // Next-state logic
  always_comb begin
    sync_cnt_d = sync_cnt_q;
    fs_idle_d  = fs_idle_q;
    busy_d     = busy_q;
    bit_cnt_d  = bit_cnt_q;
    shift_d    = shift_q;
    word_done  = 1'b0;
    word_val   = {shift_q[WORD_BITS-2:0], data_lvl};
    if (sample_en) begin
      fs_idle_d = ~fs_act;
      if (!synced) sync_cnt_d = sync_cnt_q + 1'b1;
      if (busy_q) begin
        shift_d = {shift_q[WORD_BITS-2:0], data_lvl};
        if (bit_cnt_q == LAST_BIT) begin
          word_done = 1'b1;
          busy_d    = 1'b0;
          bit_cnt_d = '0;
        end else begin
          bit_cnt_d = bit_cnt_q + 1'b1;
        end
      end else if (synced && fs_act && fs_idle_q) begin
        busy_d    = 1'b1;
        bit_cnt_d = BCW'(1);
        shift_d   = {{(WORD_BITS-1){1'b0}}, data_lvl};
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q   <= 1'b0;
      clk_prev_q <= 1'b0;
      sync_cnt_q <= '0;
      fs_idle_q  <= 1'b0;
      busy_q     <= 1'b0;
      bit_cnt_q  <= '0;
      shift_q    <= '0;
    end else begin
      primed_q   <= 1'b1;
      clk_prev_q <= clk_lvl;
      sync_cnt_q <= sync_cnt_d;
      fs_idle_q  <= fs_idle_d;
      busy_q     <= busy_d;
      bit_cnt_q  <= bit_cnt_d;
      shift_q    <= shift_d;
    end
  end

  // R4: synchronization, once reached, is kept
  a_r4_synced_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    synced |=> synced);
  // R4: no word is in progress before synchronization
  a_r4_busy_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> synced);
  // R6: bit counter stays inside the word
  a_r6_bitcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt_q < BCW'(WORD_BITS));
endmodule

// File: rtl/fsrx_holding.sv
module fsrx_holding #(
  parameter int unsigned WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 word_done,
  input  logic [WORD_BITS-1:0] word_val,
  input  logic                 rd_strobe,
  output logic [WORD_BITS-1:0] hold_word,
  output logic                 hold_ready,
  output logic                 hold_overrun
);
  logic [WORD_BITS-1:0] word_q, word_d;
  logic                 ready_q, ready_d;
  logic                 ovr_q, ovr_d;

  // Read clears the flags; a completing word is judged against the old flag
  always_comb begin
    word_d  = word_q;
    ready_d = ready_q & ~rd_strobe;
    ovr_d   = ovr_q & ~rd_strobe;
    if (word_done) begin
      if (ready_q) begin
        ovr_d = 1'b1;
      end else begin
        word_d  = word_val;
        ready_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      word_q  <= word_d;
      ready_q <= ready_d;
      ovr_q   <= ovr_d;
    end
  end

  assign hold_word    = word_q;
  assign hold_ready   = ready_q;
  assign hold_overrun = ovr_q;

  // R8: ready only rises after a completed word
  a_r8_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ready) |-> $past(word_done));
  // R10: overrun only rises when the register was already full
  a_r10_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_overrun) |-> $past(hold_ready));
  // R10: a held word is not overwritten while ready stays set
  a_r10_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ready && $past(hold_ready)) |-> $stable(hold_word));
endmodule

// File: rtl/fsrx_top.sv
module fsrx_top
  import fsrx_pkg::*;
#(
  parameter int unsigned WORD_BITS   = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SYNC_EDGES  = SYNC_EDGES_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_clk,
  input  logic                 rx_fs,
  input  logic                 rx_data,
  input  logic                 cfg_edge,
  input  logic                 cfg_fs_active_low,
  input  logic                 rd_strobe,
  output logic [WORD_BITS-1:0] rx_word,
  output logic                 rx_ready,
  output logic                 rx_overrun,
  output logic                 rx_synced
);
  localparam int unsigned LINES = 3;

  logic [LINES-1:0]     lines_s;
  logic                 done;
  logic [WORD_BITS-1:0] done_word;

  fsrx_in_sync #(
    .LINES  (LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({rx_clk, rx_fs, rx_data}),
    .dout  (lines_s)
  );

  fsrx_frame_ctrl #(
    .WORD_BITS  (WORD_BITS),
    .SYNC_EDGES (SYNC_EDGES)
  ) u_ctrl (
    .clk               (clk),
    .rst_n             (rst_n),
    .clk_lvl           (lines_s[2]),
    .fs_lvl            (lines_s[1]),
    .data_lvl          (lines_s[0]),
    .cfg_edge          (cfg_edge),
    .cfg_fs_active_low (cfg_fs_active_low),
    .synced            (rx_synced),
    .word_done         (done),
    .word_val          (done_word)
  );

  fsrx_holding #(
    .WORD_BITS (WORD_BITS)
  ) u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_done    (done),
    .word_val     (done_word),
    .rd_strobe    (rd_strobe),
    .hold_word    (rx_word),
    .hold_ready   (rx_ready),
    .hold_overrun (rx_overrun)
  );

  // R9: a read leaves the flags clear on the next cycle unless a word lands
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !done) |=> (!rx_ready && !rx_overrun));
endmodule

// File: tb/fsrx_top_tb_top.sv
module fsrx_top_tb_top;
  localparam int W = 8;
  localparam int H = 6;

  logic         clk;
  logic         rst_n;
  logic         rx_clk, rx_fs, rx_data;
  logic         cfg_edge, cfg_fs_active_low, rd_strobe;
  logic [W-1:0] rx_word;
  logic         rx_ready, rx_overrun, rx_synced;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [W-1:0] m_word;
  logic         m_ready, m_ovr;

  fsrx_top #(.WORD_BITS(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_clk(rx_clk), .rx_fs(rx_fs), .rx_data(rx_data),
    .cfg_edge(cfg_edge), .cfg_fs_active_low(cfg_fs_active_low), .rd_strobe(rd_strobe),
    .rx_word(rx_word), .rx_ready(rx_ready), .rx_overrun(rx_overrun), .rx_synced(rx_synced)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic fs_level(input logic active);
    return cfg_fs_active_low ? ~active : active;
  endfunction

  function automatic logic idle_clk();
    return cfg_edge ? 1'b0 : 1'b1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic act, input logic d);
    rx_fs   = fs_level(act);
    rx_data = d;
    rx_clk  = idle_clk();
    repeat (H) @(negedge clk);
    rx_clk = ~idle_clk();
    repeat (H) @(negedge clk);
  endtask

  task automatic do_reset(input logic edge_sel, input logic act_low);
    rst_n = 1'b0;
    cfg_edge = edge_sel;
    cfg_fs_active_low = act_low;
    rd_strobe = 1'b0;
    rx_clk = idle_clk();
    rx_fs = fs_level(1'b0);
    rx_data = 1'b0;
    m_word = '0; m_ready = 1'b0; m_ovr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Idle tick, then one word; optional full-width pulse and mid-word glitch
  task automatic send_word(input logic [W-1:0] w, input logic full, input logic glitch);
    tick(1'b0, 1'($urandom));
    for (int i = W - 1; i >= 0; i--) begin
      logic act;
      act = (i == W - 1) || full;
      if (glitch && i == 4) act = 1'b0;
      if (glitch && i == 3) act = 1'b1;
      tick(act, w[i]);
    end
    if (m_ready) m_ovr = 1'b1;
    else begin m_word = w; m_ready = 1'b1; end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_model(input string req);
    chk({req, " word"},    32'(rx_word),    32'(m_word));
    chk({req, " ready"},   32'(rx_ready),   32'(m_ready));
    chk({req, " overrun"}, 32'(rx_overrun), 32'(m_ovr));
  endtask

  task automatic do_read();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    m_ready = 1'b0; m_ovr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    do_reset(1'b1, 1'b1);
    chk("R1 ready", 32'(rx_ready), 0);
    chk("R1 overrun", 32'(rx_overrun), 0);
    chk("R1 synced", 32'(rx_synced), 0);
    chk("R1 word", 32'(rx_word), 0);

    // R4: fs inactive on edge 1, active on edge 2 (ignored), then held active
    tick(1'b0, 1'b1);
    chk("R4 synced after one edge", 32'(rx_synced), 0);
    tick(1'b1, 1'b1);
    chk("R4 synced after two edges", 32'(rx_synced), 1);
    for (int i = 0; i < W + 1; i++) tick(1'b1, 1'($urandom));
    chk("R4 R5 no frame from sync-phase transition", 32'(rx_ready), 0);

    // R2: gated clock - fs toggles with rx_clk parked, clock resumes with fs active
    rx_fs = fs_level(1'b0);
    repeat (3 * H) @(negedge clk);
    rx_fs = fs_level(1'b1);
    repeat (3 * H) @(negedge clk);
    chk("R2 no effect without clock edge", 32'(rx_ready), 0);
    for (int i = 0; i < 3 * W; i++) tick(1'b1, 1'($urandom));
    chk("R5 always-active fs gives no word", 32'(rx_ready), 0);
    chk("R4 synced stays high", 32'(rx_synced), 1);

    // R6 R8: one-bit pulse frame
    send_word(8'hA5, 1'b0, 1'b0);
    check_model("R6 R8 first word");
    chk("R6 msb first", 32'(rx_word), 32'h0A5);

    // R9: read
    do_read();
    check_model("R9 read");
    chk("R9 word retained", 32'(rx_word), 32'h0A5);

    // R7: mid-word glitch ignored
    send_word(8'h3C, 1'b0, 1'b1);
    check_model("R7 glitch pulse");
    do_read();
    send_word(8'hC3, 1'b1, 1'b1);
    check_model("R7 glitch full");

    // R10: overrun
    send_word(8'h5A, 1'b0, 1'b0);
    check_model("R10 overrun");
    chk("R10 old word kept", 32'(rx_word), 32'h0C3);
    do_read();
    check_model("R9 read clears overrun");

    // R2 R3: falling edge, active-high framing, then random mixes
    for (int c = 0; c < 6; c++) begin
      logic e, al;
      e  = (c == 0) ? 1'b0 : 1'($urandom);
      al = (c == 0) ? 1'b0 : 1'($urandom);
      do_reset(e, al);
      tick(1'b0, 1'b0);
      tick(1'b0, 1'b0);
      chk("R4 synced", 32'(rx_synced), 1);
      for (int k = 0; k < 6; k++) begin
        logic [W-1:0] w;
        w = W'($urandom);
        if ($urandom % 3 != 0 && rx_ready) do_read();
        send_word(w, 1'($urandom), 1'($urandom));
        check_model("R2 R3 R6 R8 R10 random");
      end
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule